// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block decides which of five interrupt requests an 8-bit core takes and when it takes it. The sources have a fixed ranking. A non-maskable source is armed by a rising edge and must still be high when sampled. An edge-latched source keeps its request in a flip-flop even while it is masked. Two level sources are taken only while their pin is high. An external source does not get a restart address; the block asks the core for an acknowledge cycle instead. The core raises `sample_i` in the next-to-last clock of each instruction and while it sits in hold or halt. One clock later the block reports the winning source and its restart vector. The core then pushes the program counter and jumps to that address.

The core writes a control byte through the set-mask operation. That byte sets the three mask bits, can clear the edge latch and can load the serial output bit. The read-mask operation returns a status byte, taken combinationally from `status_o`. Enable and disable instruction pulses drive the interrupt-enable flag. Every acceptance clears the flag. When the non-maskable source is accepted, the flag value just before acceptance is kept. The first status read after that returns the kept value.

Top module: `vic5_ctrl`

## Requirements
- R1: Ranking, highest first: non-maskable (src_o=0), edge-latched (1), high-level (2), low-level (3), external (4). A clock with `sample_i` high and at least one qualified source gives `accept_o`=1 for exactly one cycle, on the next clock, with `src_o` naming the winner. No acceptance occurs without `sample_i`.
- R2: `vector_o` is 0x24, 0x3C, 0x34 or 0x2C for sources 0 to 3. For the external source `vector_o` is 0x00 and `ack_req_o`=1. In every other cycle `vector_o` is 0x00 and `ack_req_o` is 0.
- R3: A rising edge on `edge_irq_i` sets the edge latch, even while that source is masked. The latch clears when its source is accepted, when a set-mask byte has bit 4 = 1, or on reset. A new rising edge in the same clock as a clear leaves the latch set.
- R4: The high-level, low-level and external sources qualify only if their pin is high at sampling, the enable flag is 1 and, for the first two, the mask bit is 0. The edge-latched source also needs the flag set and its mask bit clear.
- R5: The non-maskable source ignores masks and the enable flag. It qualifies when `nmi_i` is high at sampling and a rising edge has occurred since its last acceptance. A pin that stays high is not accepted a second time.
- R6: `ei_i` sets the enable flag (`ie_o`) and `di_i` clears it. Any acceptance clears it, and acceptance has priority over `ei_i`/`di_i` in the same clock. `di_i` has priority over `ei_i`.
- R7: Accepting the non-maskable source saves the flag value from before acceptance. Until the next `rdmask_i` pulse, status bit 3 shows the saved value. After that pulse it shows `ie_o`.
- R8: Status byte layout: bit 7 = `sin_i`, bit 6 = edge latch, bit 5 = `lvl_hi_i`, bit 4 = `lvl_lo_i`, bit 3 = enable as in R7, bits 2/1/0 = masks of the edge, high-level and low-level sources.
- R9: Set-mask byte layout: when bit 3 = 1, bits 2/1/0 load the edge, high-level and low-level masks. Otherwise the masks hold. Bit 4 clears the edge latch. When bit 6 = 1, `sout_o` loads bit 7. Otherwise `sout_o` holds.
- R10: Reset gives `ie_o`=0, edge latch 0, masks 111, `sout_o`=0, no acceptance and no saved value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request pin |
| edge_irq_i | input | 1 | Edge-latched request pin |
| lvl_hi_i | input | 1 | Higher level-sensitive request pin |
| lvl_lo_i | input | 1 | Lower level-sensitive request pin |
| ext_irq_i | input | 1 | External request that needs an acknowledge cycle |
| sample_i | input | 1 | Sampling window from the core |
| ei_i | input | 1 | Enable instruction pulse |
| di_i | input | 1 | Disable instruction pulse |
| setmask_i | input | 1 | Set-mask write strobe |
| setmask_data_i | input | 8 | Set-mask control byte |
| rdmask_i | input | 1 | Read-mask strobe |
| sin_i | input | 1 | Serial input bit |
| accept_o | output | 1 | Acceptance pulse |
| src_o | output | 3 | Accepted source code |
| vector_o | output | 8 | Restart address |
| ack_req_o | output | 1 | Acknowledge cycle request for the external source |
| ie_o | output | 1 | Interrupt-enable flag |
| sout_o | output | 1 | Serial output bit |
| status_o | output | 8 | Status byte returned by a read-mask operation |

## Verification
The assertions check a set of properties on every clock:
- the latch sets after an edge and clears after a clear;
- the masks hold unless a set-mask byte has its load bit set;
- the serial output holds between writes;
- the enable flag is low during an acceptance;
- a sampled non-maskable request wins the next clock;
- the saved flag value appears right after a non-maskable acceptance.

Only the bench's scenarios can show the rest:
- the full ranking sweep, in which each acceptance exposes the next source down;
- the refusal of a non-maskable pin that stays high;
- that the edge latch keeps a request while masked and hands it on once unmasked;
- that a read-mask operation switches status bit 3 back to the live flag.

// File: rtl/vic5_pkg.sv
package vic5_pkg;
  localparam int NSRC  = 5;
  localparam int MASKW = 3;
  localparam int BYTEW = 8;

  typedef enum logic [2:0] {
    SRC_NMI  = 3'd0,
    SRC_EDGE = 3'd1,
    SRC_HI   = 3'd2,
    SRC_LO   = 3'd3,
    SRC_EXT  = 3'd4
  } src_e;

  function automatic logic [BYTEW-1:0] vec_of(src_e s);
    case (s)
      SRC_NMI:  return 8'h24;
      SRC_EDGE: return 8'h3C;
      SRC_HI:   return 8'h34;
      SRC_LO:   return 8'h2C;
      default:  return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/vic5_edge_latch.sv
module vic5_edge_latch #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;

  assign rise = pin_i & ~prev_q;

  // a fresh edge wins over a clear in the same clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_o <= '0;
    end else begin
      prev_q <= pin_i;
      pend_o <= rise | (pend_o & ~clr_i);
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_chk
    // R3
    edge_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise[k] |=> pend_o[k]);
    // R3
    clear_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[k] && !rise[k] |=> !pend_o[k]);
  end
endmodule

// File: rtl/vic5_mask_reg.sv
module vic5_mask_reg
  import vic5_pkg::*;
#(
  parameter int MW = MASKW,
  parameter int DW = BYTEW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic [MW-1:0] mask_o,
  output logic          sout_o
);
  localparam int MASK_EN  = 3;
  localparam int SOUT_EN  = 6;
  localparam int SOUT_VAL = 7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      sout_o <= 1'b0;
    end else if (wr_i) begin
      if (data_i[MASK_EN]) mask_o <= data_i[MW-1:0];
      if (data_i[SOUT_EN]) sout_o <= data_i[SOUT_VAL];
    end
  end

  // R9
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && data_i[MASK_EN]) |=> $stable(mask_o));
endmodule

// File: rtl/vic5_arbiter.sv
module vic5_arbiter
  import vic5_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [N-1:0]     cand_i,
  output logic [N-1:0]     win_o,
  output logic             accept_o,
  output src_e             src_o,
  output logic [BYTEW-1:0] vector_o,
  output logic             ack_req_o
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] idx;

  // scan from lowest rank upward so the highest qualified source remains
  always_comb begin
    win_o = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sample_i && cand_i[i]) begin
        win_o    = '0;
        win_o[i] = 1'b1;
        idx      = IW'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o  <= 1'b0;
      src_o     <= SRC_NMI;
      vector_o  <= '0;
      ack_req_o <= 1'b0;
    end else begin
      accept_o  <= |win_o;
      src_o     <= src_e'(idx);
      vector_o  <= (|win_o) ? vec_of(src_e'(idx)) : '0;
      ack_req_o <= win_o[N-1];
    end
  end

  // R1
  nmi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && cand_i[0] |=> accept_o && src_o == SRC_NMI);
  // R1
  no_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> !accept_o);
  // R2
  edge_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && src_o == SRC_EDGE |-> vector_o == 8'h3C);
endmodule

// File: rtl/vic5_ctrl.sv
module vic5_ctrl
  import vic5_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nmi_i,
  input  logic       edge_irq_i,
  input  logic       lvl_hi_i,
  input  logic       lvl_lo_i,
  input  logic       ext_irq_i,
  input  logic       sample_i,
  input  logic       ei_i,
  input  logic       di_i,
  input  logic       setmask_i,
  input  logic [7:0] setmask_data_i,
  input  logic       rdmask_i,
  input  logic       sin_i,
  output logic       accept_o,
  output logic [2:0] src_o,
  output logic [7:0] vector_o,
  output logic       ack_req_o,
  output logic       ie_o,
  output logic       sout_o,
  output logic [7:0] status_o
);
  localparam int EDGE_CLR = 4;

  logic [1:0]       pend;   // [0] edge latch, [1] non-maskable arm
  logic [1:0]       clr;
  logic [MASKW-1:0] mask;
  logic [NSRC-1:0]  cand;
  logic [NSRC-1:0]  win;
  src_e             src_w;
  logic             ie_q;
  logic             trap_q;
  logic             save_q;

  assign clr[0] = win[1] | (setmask_i & setmask_data_i[EDGE_CLR]);
  assign clr[1] = win[0];

  vic5_edge_latch #(.W(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({nmi_i, edge_irq_i}),
    .clr_i  (clr),
    .pend_o (pend)
  );

  vic5_mask_reg #(.MW(MASKW), .DW(BYTEW)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (setmask_i),
    .data_i (setmask_data_i),
    .mask_o (mask),
    .sout_o (sout_o)
  );

  assign cand[0] = pend[1] & nmi_i;
  assign cand[1] = ie_q & ~mask[2] & pend[0];
  assign cand[2] = ie_q & ~mask[1] & lvl_hi_i;
  assign cand[3] = ie_q & ~mask[0] & lvl_lo_i;
  assign cand[4] = ie_q & ext_irq_i;

  vic5_arbiter #(.N(NSRC)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample_i),
    .cand_i    (cand),
    .win_o     (win),
    .accept_o  (accept_o),
    .src_o     (src_w),
    .vector_o  (vector_o),
    .ack_req_o (ack_req_o)
  );

  assign src_o = src_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ie_q <= 1'b0;
    else if (|win)  ie_q <= 1'b0;
    else if (di_i)  ie_q <= 1'b0;
    else if (ei_i)  ie_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q <= 1'b0;
      save_q <= 1'b0;
    end else if (win[0]) begin
      trap_q <= 1'b1;
      save_q <= ie_q;
    end else if (rdmask_i) begin
      trap_q <= 1'b0;
    end
  end

  assign ie_o     = ie_q;
  assign status_o = {sin_i, pend[0], lvl_hi_i, lvl_lo_i,
                     trap_q ? save_q : ie_q, mask};

  // R6
  ie_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> !ie_o);
  // R5
  nmi_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && src_o == SRC_NMI |-> $past(nmi_i));
  // R7
  trap_saved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && src_o == SRC_NMI |-> status_o[3] == $past(ie_o));
  // R9
  sout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !setmask_i |=> $stable(sout_o));
endmodule

// File: tb/vic5_ctrl_test.sv
module vic5_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi = 0, edge_irq = 0, lvl_hi = 0, lvl_lo = 0, ext_irq = 0;
  logic sample = 0, ei = 0, di = 0, setmask = 0, rdmask = 0, sin = 0;
  logic [7:0] smd = '0;
  logic accept, ack_req, ie, sout;
  logic [2:0] src;
  logic [7:0] vector, status;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vic5_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .edge_irq_i(edge_irq),
    .lvl_hi_i(lvl_hi), .lvl_lo_i(lvl_lo), .ext_irq_i(ext_irq),
    .sample_i(sample), .ei_i(ei), .di_i(di), .setmask_i(setmask),
    .setmask_data_i(smd), .rdmask_i(rdmask), .sin_i(sin),
    .accept_o(accept), .src_o(src), .vector_o(vector), .ack_req_o(ack_req),
    .ie_o(ie), .sout_o(sout), .status_o(status)
  );

  task automatic chk_eq(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_ie, m_pend, m_arm, m_trapf, m_save, m_sout, m_eprev, m_nprev, m_acc, m_ack;
  bit [2:0] m_mask;
  int m_src;
  bit [7:0] m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ie = 0; m_pend = 0; m_arm = 0; m_trapf = 0; m_save = 0; m_sout = 0;
      m_eprev = 0; m_nprev = 0; m_acc = 0; m_ack = 0; m_mask = 3'b111;
      m_src = 0; m_vec = 0;
    end else begin
      bit c[5];
      int w;
      bit erise, nrise, clr_e;
      c[0] = m_arm && nmi;
      c[1] = m_ie && !m_mask[2] && m_pend;
      c[2] = m_ie && !m_mask[1] && lvl_hi;
      c[3] = m_ie && !m_mask[0] && lvl_lo;
      c[4] = m_ie && ext_irq;
      w = -1;
      if (sample) for (int i = 0; i < 5; i++) if (w < 0 && c[i]) w = i;
      m_acc = (w >= 0);
      m_src = (w < 0) ? 0 : w;
      case (w)
        0: m_vec = 8'h24;
        1: m_vec = 8'h3C;
        2: m_vec = 8'h34;
        3: m_vec = 8'h2C;
        default: m_vec = 8'h00;
      endcase
      m_ack = (w == 4);
      erise = edge_irq && !m_eprev;
      nrise = nmi && !m_nprev;
      clr_e = (w == 1) || (setmask && smd[4]);
      m_pend = erise || (m_pend && !clr_e);
      m_arm = nrise || (m_arm && w != 0);
      if (w == 0) begin m_trapf = 1; m_save = m_ie; end
      else if (rdmask) m_trapf = 0;
      if (w >= 0) m_ie = 0;
      else if (di) m_ie = 0;
      else if (ei) m_ie = 1;
      if (setmask && smd[3]) m_mask = smd[2:0];
      if (setmask && smd[6]) m_sout = smd[7];
      m_eprev = edge_irq;
      m_nprev = nmi;
    end
  end

  always @(posedge clk) begin
    #4;
    if (!done) begin
      chk_eq("R1 accept", accept, m_acc);
      if (m_acc) chk_eq("R1 src", src, m_src);
      chk_eq("R2 vector", vector, m_vec);
      chk_eq("R2 ack", ack_req, m_ack);
      chk_eq("R6 ie", ie, m_ie);
      chk_eq("R9 sout", sout, m_sout);
      chk_eq("R8 status", status,
             {sin, m_pend, lvl_hi, lvl_lo, m_trapf ? m_save : m_ie, m_mask});
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic setm(logic [7:0] d); setmask = 1; smd = d; tick(); setmask = 0; smd = '0; endtask
  task automatic samp(); sample = 1; tick(); sample = 0; endtask
  task automatic ei_p(); ei = 1; tick(); ei = 0; endtask
  task automatic edge_p(); edge_irq = 1; tick(); edge_irq = 0; endtask

  task automatic report();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) tick();
    // R10 reset state
    chk_eq("R10 ie", ie, 0);
    chk_eq("R10 accept", accept, 0);
    chk_eq("R10 sout", sout, 0);
    chk_eq("R10 masks", status[2:0], 3'b111);
    chk_eq("R10 latch", status[6], 0);
    rst_n = 1;
    tick();

    ei_p();
    chk_eq("R6 ei sets", ie, 1);
    setm(8'h08);
    chk_eq("R9 mask load", status[2:0], 0);
    lvl_lo = 1; ext_irq = 1;
    samp();
    chk_eq("R4 low level accept", accept, 1);
    chk_eq("R1 low over ext", src, 3);
    chk_eq("R2 low vector", vector, 8'h2C);
    chk_eq("R6 accept clears", ie, 0);
    samp();
    chk_eq("R4 disabled blocks", accept, 0);

    ei_p();
    setm(8'h09);
    samp();
    chk_eq("R4 masked low skipped", src, 4);
    chk_eq("R2 ext vector", vector, 8'h00);
    chk_eq("R2 ext ack", ack_req, 1);
    lvl_lo = 0; ext_irq = 0;

    setm(8'h0C);
    edge_p();
    chk_eq("R3 latched while masked", status[6], 1);
    ei_p();
    samp();
    chk_eq("R3 masked edge waits", accept, 0);
    setm(8'h08);
    samp();
    chk_eq("R3 edge accepted", src, 1);
    chk_eq("R2 edge vector", vector, 8'h3C);
    chk_eq("R3 service clears", status[6], 0);

    edge_p();
    chk_eq("R3 relatch", status[6], 1);
    setm(8'h10);
    chk_eq("R3 setmask clears", status[6], 0);
    chk_eq("R9 masks held", status[2:0], 0);

    // R5 with enable clear
    nmi = 1; tick();
    samp();
    chk_eq("R5 nmi ignores ie", accept, 1);
    chk_eq("R5 nmi src", src, 0);
    chk_eq("R2 nmi vector", vector, 8'h24);
    ei_p();
    samp();
    chk_eq("R5 no retrigger while high", accept, 0);
    nmi = 0; tick();
    nmi = 1; tick();
    samp();
    chk_eq("R5 retrigger after low", accept, 1);
    chk_eq("R7 saved enable shown", status[3], 1);
    rdmask = 1; tick(); rdmask = 0;
    chk_eq("R7 live enable after read", status[3], 0);
    nmi = 0;

    setm(8'hC0);
    chk_eq("R9 sout set", sout, 1);
    setm(8'h08);
    chk_eq("R9 sout held", sout, 1);
    setm(8'h40);
    chk_eq("R9 sout cleared", sout, 0);
    sin = 1; tick();
    chk_eq("R8 serial in bit", status[7], 1);
    sin = 0;

    // R1 full ranking sweep
    lvl_hi = 1; lvl_lo = 1; ext_irq = 1; edge_irq = 1; nmi = 1;
    tick();
    edge_irq = 0;
    tick();
    chk_eq("R8 pending field", status[6:4], 3'b111);
    ei_p(); samp(); chk_eq("R1 rank nmi", src, 0);
    ei_p(); samp(); chk_eq("R1 rank edge", src, 1);
    ei_p(); samp(); chk_eq("R1 rank high", src, 2);
    lvl_hi = 0;
    ei_p(); samp(); chk_eq("R1 rank low", src, 3);
    lvl_lo = 0;
    ei_p(); samp(); chk_eq("R1 rank ext", src, 4);
    ext_irq = 0; nmi = 0;

    ei_p();
    di = 1; tick(); di = 0;
    chk_eq("R6 di clears", ie, 0);
    ei = 1; di = 1; tick(); ei = 0; di = 0;
    chk_eq("R6 di wins", ie, 0);

    setm(8'hC0);
    edge_p();
    rst_n = 0; tick();
    chk_eq("R10 sout reset", sout, 0);
    chk_eq("R10 latch reset", status[6], 0);
    chk_eq("R10 mask reset", status[2:0], 3'b111);
    chk_eq("R10 ie reset", ie, 0);
    rst_n = 1;
    repeat (3) tick();
    report();
  end
endmodule